// File: doc/BRIEF.md
# Reloading Up-Counter Timer with Selectable Count Rate

This block is a 12-bit up-counter that never wraps to zero: after it reaches its top value FFFh it restarts from a programmable reload value, so the count period is set by software. The count rate is chosen by a 2-bit select field. The choices are stopped, a slow timebase tick, every system clock, and a fast tick. The slow and fast sources come in as single-cycle tick-enable inputs in the system clock domain.

An 8-bit host reaches the block through a small byte-wide register bank. The bank holds a control/status register, the reload value, a compare value and a read-only view of the counter. Two events are flagged: the wrap to the reload value, and the counter arriving at the compare value. Each flag has its own enable. An interrupt request is raised while any enabled flag is set. Reading the status register clears both flags.

Top module: `reload_timer`

Register map (byte offsets on `bus_addr`):
- 0 control/status: bit 5 compare flag (read-only), bits 4:3 rate select, bit 2 wrap flag (read-only), bit 1 wrap interrupt enable, bit 0 compare interrupt enable, bits 7:6 read 0.
- 1 / 2: reload value high nibble (bits 3:0) / low byte.
- 3 / 4: compare value high nibble (bits 3:0) / low byte.
- 5: counter bits 11:8 in bits 3:0, bits 7:4 read 0. 6: low-byte snapshot.
- Offset 7 reads 0.

## Requirements
- R1: A synchronous active-high reset clears the counter, the reload and compare values, the select field, both enables and both flags, and holds `irq` low.
- R2: The counter advances only in cycles where the selected source is active. Select 00 means stopped, 01 means `tick_slow`, 10 means every clock and 11 means `tick_fast`. With select 00 the counter holds its value.
- R3: On each advance below FFFh the counter increases by exactly one.
- R4: On an advance at FFFh the counter loads the reload value and sets the wrap flag (status bit 2).
- R5: A read of the status register (offset 0 with `bus_rd`) clears both flags at that clock edge. If a flag sets in the same cycle, the set wins.
- R6: The compare flag (status bit 5) sets at the edge where the counter takes on a value equal to the compare value.
- R7: `irq` is high exactly when (wrap flag AND bit 1) OR (compare flag AND bit 0).
- R8: Offset 5 returns the counter's upper four bits with bits 7:4 zero. Reading it captures the low byte at the same edge, and offset 6 returns that captured byte.
- R9: Status bits 4:3, 1 and 0 are writable and read back as written. Writes to the flag bits 5 and 2 and to bits 7:6 have no effect. The reload and compare high bytes keep only bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_rd | input | 1 | Read strobe; its side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_slow | input | 1 | Slow timebase tick enable |
| tick_fast | input | 1 | Fast tick enable |
| irq | output | 1 | Interrupt request |

## Verification
A counter that skipped or repeated a step would show at the next counter read. It would also shift every later wrap, so the wrap flag would appear in the status register several cycles early or late. A flag that was lost in a clear/set collision would be visible at the very next status read, and `irq` would differ in that cycle. A stale or misplaced snapshot shows as soon as offset 6 is read after offset 5.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CSR   = 3'd0,
        A_RLD_H = 3'd1,
        A_RLD_L = 3'd2,
        A_CMP_H = 3'd3,
        A_CMP_L = 3'd4,
        A_CNT_H = 3'd5,
        A_CNT_L = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        CK_OFF  = 2'd0,
        CK_SLOW = 2'd1,
        CK_SYS  = 2'd2,
        CK_FAST = 2'd3
    } rate_sel_e;

    typedef struct packed {
        rate_sel_e sel;
        logic      wrap_ie;
        logic      cmp_ie;
    } ctrl_t;

    // next value of an up-counter that restarts from rld after its top value
    function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                    input logic [CNT_W-1:0] rld);
        return (cur == {CNT_W{1'b1}}) ? rld : cur + 1'b1;
    endfunction

endpackage

// File: rtl/rate_select.sv
module rate_select
    import rtimer_pkg::*;
(
    input  rate_sel_e sel,
    input  logic      tick_slow,
    input  logic      tick_fast,
    output logic      advance
);
    always_comb begin
        unique case (sel)
            CK_OFF:  advance = 1'b0;
            CK_SLOW: advance = tick_slow;
            CK_SYS:  advance = 1'b1;
            CK_FAST: advance = tick_fast;
            default: advance = 1'b0;
        endcase
    end
endmodule

// File: rtl/count_core.sv
module count_core
    import rtimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] compare,
    output logic [W-1:0] count,
    output logic         wrap_evt,
    output logic         match_evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;

    always_comb begin
        cnt_nx    = (cnt_q == TOP) ? reload : cnt_q + 1'b1;
        wrap_evt  = advance && (cnt_q == TOP);
        match_evt = advance && (cnt_nx == compare);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (advance) cnt_q <= cnt_nx;
    end

    assign count = cnt_q;

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r4_restart_from_reload: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q == TOP) |=> (cnt_q == $past(reload)));
    a_r2_hold_without_advance: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cnt_q));
endmodule

// File: rtl/event_flag.sv
module event_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtimer_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_slow,
    input  logic          tick_fast,
    output logic          irq
);
    localparam int HI_W = CW - DW;
    localparam int NFLG = 2;
    localparam int F_WRAP = 0;
    localparam int F_CMP  = 1;

    ctrl_t          ctrl_q;
    logic [CW-1:0]  rld_q, cmp_q, count;
    logic [DW-1:0]  snap_q;
    logic           advance, wrap_evt, match_evt;
    logic [NFLG-1:0] flag_set, flags;
    logic           stat_rd;
    logic [2*DW-1:0] cnt16, rld16, cmp16;

    rate_select u_rate (
        .sel       (ctrl_q.sel),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .advance   (advance)
    );

    count_core #(.W(CW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .reload    (rld_q),
        .compare   (cmp_q),
        .count     (count),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt)
    );

    assign stat_rd          = bus_rd && (bus_addr == A_CSR);
    assign flag_set[F_WRAP] = wrap_evt;
    assign flag_set[F_CMP]  = match_evt;

    for (genvar g = 0; g < NFLG; g++) begin : g_flag
        event_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (flag_set[g]),
            .clr  (stat_rd),
            .flag (flags[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld_q  <= '0;
            cmp_q  <= '0;
            snap_q <= '0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    A_CSR: begin
                        ctrl_q.sel     <= rate_sel_e'(bus_wdata[4:3]);
                        ctrl_q.wrap_ie <= bus_wdata[1];
                        ctrl_q.cmp_ie  <= bus_wdata[0];
                    end
                    A_RLD_H: rld_q[CW-1:DW] <= bus_wdata[HI_W-1:0];
                    A_RLD_L: rld_q[DW-1:0]  <= bus_wdata;
                    A_CMP_H: cmp_q[CW-1:DW] <= bus_wdata[HI_W-1:0];
                    A_CMP_L: cmp_q[DW-1:0]  <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == A_CNT_H) snap_q <= count[DW-1:0];
        end
    end

    always_comb begin
        cnt16 = (2*DW)'(count);
        rld16 = (2*DW)'(rld_q);
        cmp16 = (2*DW)'(cmp_q);
        unique case (bus_addr)
            A_CSR:   bus_rdata = {2'b00, flags[F_CMP], ctrl_q.sel, flags[F_WRAP],
                                  ctrl_q.wrap_ie, ctrl_q.cmp_ie};
            A_RLD_H: bus_rdata = rld16[2*DW-1:DW];
            A_RLD_L: bus_rdata = rld16[DW-1:0];
            A_CMP_H: bus_rdata = cmp16[2*DW-1:DW];
            A_CMP_L: bus_rdata = cmp16[DW-1:0];
            A_CNT_H: bus_rdata = cnt16[2*DW-1:DW];
            A_CNT_L: bus_rdata = snap_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (flags[F_WRAP] && ctrl_q.wrap_ie) || (flags[F_CMP] && ctrl_q.cmp_ie);

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.sel == CK_OFF) |=> $stable(count));
    a_r6_match_flags: assert property (@(posedge clk) disable iff (rst)
        (advance && next_count(count, rld_q) == cmp_q) |=> flags[F_CMP]);
    a_r4_wrap_flags: assert property (@(posedge clk) disable iff (rst)
        (advance && count == {CW{1'b1}}) |=> flags[F_WRAP]);
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.wrap_ie && !ctrl_q.cmp_ie) |-> !irq);
    a_r8_hi_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CNT_H) |-> (bus_rdata[DW-1:HI_W] == '0));
endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_slow = 1'b0, tick_fast = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic [1:0]  m_sel;
    logic        m_wie, m_cie, m_wf, m_cf;
    logic [11:0] m_rld, m_cmp, m_cnt;
    logic [7:0]  m_snap;

    reload_timer u_reload_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {2'b00, m_cf, m_sel, m_wf, m_wie, m_cie};
            3'd1: return {4'h0, m_rld[11:8]};
            3'd2: return m_rld[7:0];
            3'd3: return {4'h0, m_cmp[11:8]};
            3'd4: return m_cmp[7:0];
            3'd5: return {4'h0, m_cnt[11:8]};
            3'd6: return m_snap;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_wf && m_wie) || (m_cf && m_cie);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_sel = 2'd0; m_wie = 0; m_cie = 0; m_wf = 0; m_cf = 0;
        m_rld = '0; m_cmp = '0; m_cnt = '0; m_snap = '0;
    endtask

    // one bus cycle; reads are checked before the edge, the model steps after it
    task automatic cyc(input logic [2:0] a, input logic wr, input logic rd,
                       input logic [7:0] wd, input logic ts, input logic tf,
                       input string req);
        logic adv, wset, cset, clr;
        logic [11:0] nc;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        tick_slow = ts; tick_fast = tf;
        #1;
        if (rd) chk(req, bus_rdata, exp_read(a));
        chk("R7 irq", {7'd0, irq}, {7'd0, exp_irq()});
        case (m_sel)
            2'd1: adv = ts;
            2'd2: adv = 1'b1;
            2'd3: adv = tf;
            default: adv = 1'b0;
        endcase
        nc   = (m_cnt == 12'hFFF) ? m_rld : m_cnt + 12'd1;
        wset = adv && (m_cnt == 12'hFFF);
        cset = adv && (nc == m_cmp);
        clr  = rd && (a == 3'd0);
        @(posedge clk);
        if (rd && a == 3'd5) m_snap = m_cnt[7:0];
        if (adv) m_cnt = nc;
        m_wf = wset | (m_wf & ~clr);
        m_cf = cset | (m_cf & ~clr);
        if (wr) begin
            case (a)
                3'd0: begin m_sel = wd[4:3]; m_wie = wd[1]; m_cie = wd[0]; end
                3'd1: m_rld[11:8] = wd[3:0];
                3'd2: m_rld[7:0]  = wd;
                3'd3: m_cmp[11:8] = wd[3:0];
                3'd4: m_cmp[7:0]  = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        cyc(a, 1'b1, 1'b0, d, 1'b0, 1'b0, "write");
    endtask

    task automatic rd_reg(input logic [2:0] a, input string req);
        cyc(a, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(3'd7, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "idle");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: everything reads as cleared
        for (int a = 0; a < 8; a++) rd_reg(3'(a), "R1 reset value");
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        // R2: stopped counter ignores both ticks
        for (int i = 0; i < 20; i++) cyc(3'd7, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R2");
        rd_reg(3'd5, "R2 stopped high");
        rd_reg(3'd6, "R2 stopped low");

        // R9: flag bits and top bits not writable
        wr_reg(3'd0, 8'hE4);
        rd_reg(3'd0, "R9 csr ro bits");
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd1, "R9 reload high nibble");
        wr_reg(3'd2, 8'hF0);
        wr_reg(3'd3, 8'hAF);
        wr_reg(3'd4, 8'hF8);
        rd_reg(3'd3, "R9 compare high nibble");
        rd_reg(3'd4, "R9 compare low");

        // R3/R4: full run on the system clock up to the first wrap
        wr_reg(3'd0, 8'h13);
        idle(300);
        rd_reg(3'd5, "R3 count high");
        rd_reg(3'd6, "R8 snapshot low");
        idle(3800);
        rd_reg(3'd5, "R4 count high near wrap");
        rd_reg(3'd6, "R4 count low near wrap");
        rd_reg(3'd0, "R4 R6 flags");
        // R5: back-to-back status reads cross several wraps and matches
        for (int i = 0; i < 48; i++) rd_reg(3'd0, "R5 status read");
        rd_reg(3'd5, "R8 high");
        rd_reg(3'd6, "R8 low");

        // R2: slow and fast sources
        wr_reg(3'd0, 8'h0B);
        for (int i = 0; i < 60; i++)
            cyc(3'd7, 1'b0, 1'b0, 8'h00, 1'($urandom_range(0, 1)), 1'b1, "R2 slow");
        rd_reg(3'd5, "R2 slow high");
        rd_reg(3'd6, "R2 slow low");
        wr_reg(3'd0, 8'h19);
        for (int i = 0; i < 60; i++)
            cyc(3'd7, 1'b0, 1'b0, 8'h00, 1'b1, 1'($urandom_range(0, 1)), "R2 fast");
        rd_reg(3'd5, "R2 fast high");
        rd_reg(3'd6, "R2 fast low");

        // mixed random traffic
        wr_reg(3'd1, 8'h0F);
        wr_reg(3'd2, 8'hC0);
        for (int i = 0; i < 4000; i++) begin
            int kind;
            logic [2:0] a;
            logic [7:0] d;
            kind = $urandom_range(0, 9);
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            if (kind == 0) begin
                if (a == 3'd1 || a == 3'd2) a = 3'd0;
                if (a == 3'd0 && d[4:3] == 2'd0) d[4] = 1'b1;
                cyc(a, 1'b1, 1'b0, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    "R9 random write");
            end else if (kind < 4) begin
                cyc(a, 1'b0, 1'b1, 8'h00, 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), "R8 R5 random read");
            end else begin
                cyc(3'd7, 1'b0, 1'b0, 8'h00, 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), "R2 random idle");
            end
        end
        for (int a = 0; a < 8; a++) rd_reg(3'(a), "R6 final state");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule